// File: doc/BRIEF.md
# Detector Indicator LED Pattern Generator

This block turns the detector's current condition into flash patterns on a red and a green indicator LED. A slow time-base tick, one clock wide and nominally every 10.4 ms, paces every pattern. Every red flash lasts exactly one tick interval. How often it repeats depends on the condition, and a fixed priority picks the condition: a local alarm first, then a remote-only alarm, then the reduced-sensitivity timer, then standby. A local alarm flashes faster with the temporal horn pattern than with the continuous one. A remote alarm with no local alarm keeps the red LED dark.

The green LED shows a latched alarm memory. While the memory is set and no local alarm is sounding, it gives a burst of three one-tick flashes. The flashes are a fixed gap apart, and the burst repeats once per frame. After a set number of frames, about a day at default settings, the indication stops by itself. It starts again only when the memory is cleared and set again. All periods are parameters counted in ticks, so the block can be rescaled to another time base.

Top module: `led_indicator_gen`

## Requirements
- R1: While rst_n is low, red_led and green_led are both low.
- R2: In standby (no local alarm, no remote alarm, no timer mode), red_led is high for one tick interval once every STBY_TICKS ticks. The pattern advances only on cycles where tick is high.
- R3: During a local alarm with horn_temporal=1, red_led flashes for one tick interval every TEMP_TICKS ticks.
- R4: During a local alarm with horn_temporal=0, red_led flashes for one tick interval every CONT_TICKS ticks.
- R5: In timer mode with no local and no remote alarm, red_led flashes for one tick interval every TIMER_TICKS ticks.
- R6: While remote_alarm is high and local_alarm is low, red_led stays low, even if timer_mode is high.
- R7: A local alarm takes priority over a remote alarm and over timer mode in choosing the red period.
- R8: While latch_mem is high and local_alarm is low, green_led is high during the tick intervals at offsets 0, GAP_TICKS and 2*GAP_TICKS of each FRAME_TICKS-long frame, and low at all other offsets. Offset 0 is the cycle after enabling. green_led is low whenever latch_mem is low.
- R9: After LIFE_FRAMES complete frames the green indication stops. It resumes only after latch_mem goes low and then high again.
- R10: While local_alarm is high, green_led stays low. When local_alarm is released with latch_mem still high, a new burst starts at offset 0.
- R11: When the selected red mode changes, the red period counter restarts, so a red flash begins in the cycle after the change. This also holds when tick is high in the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Time-base pulse, one clock wide |
| local_alarm | input | 1 | This unit is sensing smoke |
| horn_temporal | input | 1 | Horn pattern: 1 = temporal, 0 = continuous |
| timer_mode | input | 1 | Reduced-sensitivity timer active |
| remote_alarm | input | 1 | Another interconnected unit is alarming |
| latch_mem | input | 1 | Latched alarm memory set |
| red_led | output | 1 | Red indicator drive |
| green_led | output | 1 | Green indicator drive |

## Verification
A red mode change and a time-base tick can fall in the same clock cycle, and the counter must then either restart or advance. The bench runs a temporal alarm for a few ticks, then switches the horn pattern in the very cycle that carries a tick. It expects a flash right after that edge, followed by the full continuous period counted from there. A flash that is late by one tick, or that comes one tick early later on, is reported. The bench also releases a local alarm while latch_mem is held and checks that the green burst restarts at offset zero.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;
  typedef enum logic [2:0] {
    RM_OFF   = 3'd0,
    RM_STBY  = 3'd1,
    RM_TIMER = 3'd2,
    RM_TEMP  = 3'd3,
    RM_CONT  = 3'd4
  } red_mode_e;
endpackage

// File: rtl/led_mode_sel.sv
module led_mode_sel
  import led_ind_pkg::*;
(
  input  logic      local_alarm,
  input  logic      horn_temporal,
  input  logic      timer_mode,
  input  logic      remote_alarm,
  output red_mode_e mode
);
  // fixed priority: local > remote (dark) > timer > standby
  always_comb begin
    if (local_alarm)       mode = horn_temporal ? RM_TEMP : RM_CONT;
    else if (remote_alarm) mode = RM_OFF;
    else if (timer_mode)   mode = RM_TIMER;
    else                   mode = RM_STBY;
  end
endmodule

// File: rtl/led_red_flasher.sv
module led_red_flasher
  import led_ind_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  red_mode_e     mode,
  input  logic [CW-1:0] period,
  output logic          red
);
  red_mode_e     mode_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          chg;

  assign chg = (mode != mode_q);

  always_comb begin
    cnt_d = cnt_q;
    if (chg)
      cnt_d = '0;
    else if (tick)
      cnt_d = (cnt_q >= period - CW'(1)) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_OFF;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode;
      if (chg || tick) cnt_q <= cnt_d;
    end
  end

  assign red = (mode_q != RM_OFF) && (cnt_q == '0);
endmodule

// File: rtl/led_green_burst.sv
module led_green_burst #(
  parameter int GAP_TICKS   = 128,
  parameter int FRAME_TICKS = 4135,
  parameter int LIFE_FRAMES = 2001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic latch_mem,
  input  logic local_alarm,
  output logic green
);
  localparam int GW = $clog2(FRAME_TICKS);
  localparam int LW = $clog2(LIFE_FRAMES + 1);
  localparam logic [GW-1:0] POS1 = GW'(GAP_TICKS);
  localparam logic [GW-1:0] POS2 = GW'(2 * GAP_TICKS);
  localparam logic [GW-1:0] LAST = GW'(FRAME_TICKS - 1);
  localparam logic [LW-1:0] LIFE = LW'(LIFE_FRAMES);

  logic          en, en_q;
  logic [GW-1:0] pos_q, pos_d;
  logic [LW-1:0] life_q, life_d;
  logic          expired, wrap;

  assign en      = latch_mem && !local_alarm;
  assign expired = (life_q == LIFE);
  assign wrap    = en_q && tick && (pos_q == LAST);

  always_comb begin
    pos_d = pos_q;
    if (en && !en_q)
      pos_d = '0;
    else if (en_q && tick)
      pos_d = (pos_q == LAST) ? '0 : pos_q + GW'(1);
  end

  always_comb begin
    life_d = life_q;
    if (!latch_mem)
      life_d = '0;
    else if (wrap && !expired)
      life_d = life_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pos_q  <= '0;
      life_q <= '0;
    end else begin
      en_q   <= en;
      pos_q  <= pos_d;
      life_q <= life_d;
    end
  end

  assign green = en_q && !expired &&
                 ((pos_q == '0) || (pos_q == POS1) || (pos_q == POS2));
endmodule

// File: rtl/led_indicator_gen.sv
module led_indicator_gen
  import led_ind_pkg::*;
#(
  parameter int STBY_TICKS  = 3308,
  parameter int TEMP_TICKS  = 48,
  parameter int CONT_TICKS  = 64,
  parameter int TIMER_TICKS = 1029,
  parameter int GAP_TICKS   = 128,
  parameter int FRAME_TICKS = 4135,
  parameter int LIFE_FRAMES = 2001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic local_alarm,
  input  logic horn_temporal,
  input  logic timer_mode,
  input  logic remote_alarm,
  input  logic latch_mem,
  output logic red_led,
  output logic green_led
);
  localparam int MAX_A = (STBY_TICKS > TIMER_TICKS) ? STBY_TICKS : TIMER_TICKS;
  localparam int MAX_B = (TEMP_TICKS > CONT_TICKS) ? TEMP_TICKS : CONT_TICKS;
  localparam int MAXP  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXP + 1);

  red_mode_e     mode;
  logic [CW-1:0] period;

  led_mode_sel u_sel (
    .local_alarm  (local_alarm),
    .horn_temporal(horn_temporal),
    .timer_mode   (timer_mode),
    .remote_alarm (remote_alarm),
    .mode         (mode)
  );

  always_comb begin
    unique case (mode)
      RM_STBY:  period = CW'(STBY_TICKS);
      RM_TIMER: period = CW'(TIMER_TICKS);
      RM_TEMP:  period = CW'(TEMP_TICKS);
      RM_CONT:  period = CW'(CONT_TICKS);
      default:  period = CW'(1);
    endcase
  end

  led_red_flasher #(.CW(CW)) u_red (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .mode  (mode),
    .period(period),
    .red   (red_led)
  );

  led_green_burst #(
    .GAP_TICKS  (GAP_TICKS),
    .FRAME_TICKS(FRAME_TICKS),
    .LIFE_FRAMES(LIFE_FRAMES)
  ) u_green (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .latch_mem  (latch_mem),
    .local_alarm(local_alarm),
    .green      (green_led)
  );
endmodule

// File: rtl/led_indicator_chk.sv
module led_indicator_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic local_alarm,
  input logic horn_temporal,
  input logic timer_mode,
  input logic remote_alarm,
  input logic latch_mem,
  input logic red_led,
  input logic green_led
);
  logic [4:0] ins;
  assign ins = {local_alarm, horn_temporal, timer_mode, remote_alarm, latch_mem};

  p_dark_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!red_led && !green_led));

  p_remote_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_alarm && !local_alarm) |=> !red_led);

  p_green_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    local_alarm |=> !green_led);

  p_green_needs_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_mem |=> !green_led);

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !tick && $stable(ins)) |=> ($stable(red_led) && $stable(green_led)));
endmodule

bind led_indicator_gen led_indicator_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .local_alarm  (local_alarm),
  .horn_temporal(horn_temporal),
  .timer_mode   (timer_mode),
  .remote_alarm (remote_alarm),
  .latch_mem    (latch_mem),
  .red_led      (red_led),
  .green_led    (green_led)
);

// File: tb/led_indicator_gen_tb_top.sv
`timescale 1ns/1ps
module led_indicator_gen_tb_top;
  localparam int STBY = 20, TEMP = 6, CONT = 8, TIMR = 12;
  localparam int GAP = 4, FRAME = 16, LIFE = 3;

  logic clk = 1'b0;
  logic rst_n, tick, local_alarm, horn_temporal, timer_mode, remote_alarm, latch_mem;
  logic red_led, green_led;
  int vectors = 0;
  int miscomp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_indicator_gen #(
    .STBY_TICKS(STBY), .TEMP_TICKS(TEMP), .CONT_TICKS(CONT), .TIMER_TICKS(TIMR),
    .GAP_TICKS(GAP), .FRAME_TICKS(FRAME), .LIFE_FRAMES(LIFE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .local_alarm(local_alarm),
    .horn_temporal(horn_temporal), .timer_mode(timer_mode),
    .remote_alarm(remote_alarm), .latch_mem(latch_mem),
    .red_led(red_led), .green_led(green_led)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input int k);
    vectors++;
    if (got !== exp) begin
      miscomp++;
      $display("FAIL %s step %0d: got %b expected %b", tag, k, got, exp);
    end
  endtask

  task automatic set_in(input logic l, input logic h, input logic t, input logic r, input logic m);
    local_alarm = l; horn_temporal = h; timer_mode = t; remote_alarm = r; latch_mem = m;
  endtask

  task automatic do_reset(input logic l, input logic h, input logic t, input logic r, input logic m);
    rst_n = 1'b0; tick = 1'b0;
    set_in(l, h, t, r, m);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic red_run(input int per, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(red_led, (k % per) == 0, tag, k);
      step_tick();
    end
  endtask

  function automatic logic green_exp(input int k);
    int p;
    p = k % FRAME;
    return (k < LIFE * FRAME) && (p == 0 || p == GAP || p == 2 * GAP);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b0;
    set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(red_led, 1'b0, "R1 red", 0);
    chk(green_led, 1'b0, "R1 green", 0);
    step_tick();
    chk(red_led, 1'b0, "R1 red after tick", 1);
  endtask

  task automatic t_standby();
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(red_led, 1'b1, "R2 first flash", 0);
    repeat (5) @(negedge clk);
    chk(red_led, 1'b1, "R2 held without tick", 0);
    red_run(STBY, 2 * STBY + 3, "R2 standby");
    chk(green_led, 1'b0, "R8 green off without memory", 0);
  endtask

  task automatic t_temporal();
    do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    red_run(TEMP, 3 * TEMP + 1, "R3 temporal");
  endtask

  task automatic t_continuous();
    do_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    red_run(CONT, 3 * CONT + 1, "R4 continuous");
  endtask

  task automatic t_timer();
    do_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    red_run(TIMR, 2 * TIMR + 1, "R5 timer");
  endtask

  task automatic t_remote();
    do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 2 * TIMR + 2; k++) begin
      chk(red_led, 1'b0, "R6 remote dark", k);
      step_tick();
    end
  endtask

  task automatic t_priority();
    do_reset(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    red_run(TEMP, 2 * TEMP + 1, "R7 local over timer and remote");
  endtask

  task automatic t_restart();
    do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) step_tick();
    horn_temporal = 1'b0;
    @(negedge clk);
    red_run(CONT, 2 * CONT + 1, "R11 restart");
  endtask

  task automatic t_restart_on_tick();
    do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (2) step_tick();
    horn_temporal = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    red_run(CONT, 2 * CONT + 1, "R11 change with tick");
  endtask

  task automatic t_green_life();
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < LIFE * FRAME + 10; k++) begin
      chk(green_led, green_exp(k), (k < LIFE * FRAME) ? "R8 burst" : "R9 expired", k);
      step_tick();
    end
    latch_mem = 1'b0;
    @(negedge clk);
    chk(green_led, 1'b0, "R9 cleared", 0);
    latch_mem = 1'b1;
    @(negedge clk);
    chk(green_led, 1'b1, "R9 rearmed", 0);
  endtask

  task automatic t_green_masked();
    do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < FRAME + 3; k++) begin
      chk(green_led, 1'b0, "R10 masked", k);
      step_tick();
    end
    step_tick();
    local_alarm = 1'b0;
    @(negedge clk);
    for (int k = 0; k < FRAME + 1; k++) begin
      chk(green_led, green_exp(k), "R10 resume", k);
      step_tick();
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    t_reset();
    t_standby();
    t_temporal();
    t_continuous();
    t_timer();
    t_remote();
    t_priority();
    t_restart();
    t_restart_on_tick();
    t_green_life();
    t_green_masked();
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      vectors++;
      miscomp++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end
endmodule